// File: doc/BRIEF.md
# Dual-Target Sound Interrupt Controller

This block collects eleven interrupt sources from a sound subsystem and steers them to two processors. Each processor has its own bank of three registers: a pending register that records requests, an enable register that decides which pending requests reach that processor, and a write-one-to-clear register that retires pending requests. The two banks watch the same sources but are otherwise independent, so one processor can clear or mask a source without changing what the other sees.

The sound processor receives a registered 3-bit auto-vector priority level. Each source slot has a 3-bit level code. The codes are stored bit-sliced: one level register holds bit 0 of every slot's code, a second holds bit 1, and a third holds bit 2. Sources 7 to 10 share slot 7. The main processor receives one interrupt line, and the rising edge of that line also produces a one-cycle pulse that can start a DMA transfer.

Source numbering: 0 to 2 are external active-low request pins, 3 is receive data available, 4 is DMA done, 5 is the software interrupt, 6 to 8 are three timer events, 9 is transmit FIFO empty and 10 is the per-sample tick. Register selects on `bus_addr` are: 0 sound pending, 1 sound enable, 2 sound clear, 3 main pending, 4 main enable, 5 main clear, 6 level bit 0, 7 level bit 1, 8 level bit 2. Writes take effect at the clock edge where `bus_we` is high, and reads are combinational.

Top module: `snd_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `snd_ipl` is 0, and `main_irq` and `main_dma_start` are low.
- R2: A rising request on an edge-type source (every source except 3, 5 and 9) sets its bit in both pending registers at the next clock edge, whatever the enable bits hold. The bit stays set after the request goes away.
- R3: Pending bits 3 and 9 follow their source level with one cycle of delay. Writes to the clear or pending registers do not change them.
- R4: Writing 1 to a bit of a clear register (select 2 or 5) clears that pending bit in that bank only. Writing 0 leaves the bit unchanged.
- R5: Writing a pending register sets bit 5 of that bank when data bit 5 is 1. Every other data bit, and a 0 in bit 5, has no effect.
- R6: A pending source reaches a processor only while its enable bit in that processor's bank is 1. `main_irq` is the OR of pending AND enable in the main bank.
- R7: The level code of source i is {lvl2[s], lvl1[s], lvl0[s]}, where s = i for i < 7 and s = 7 for i from 7 to 10. The three level registers are 8 bits wide.
- R8: One cycle after the state changes, `snd_ipl` equals the largest level code among sources that are both pending and enabled in the sound bank, or 0 if there is none. A code of 0 never raises the level.
- R9: `main_dma_start` is high for exactly one cycle, in the first cycle that `main_irq` is high after being low.
- R10: Reads return 0 in bits 15:11 of the pending, enable and clear registers and in bits 15:8 of the level registers. A clear register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 3 | External requests, active low (sources 0 to 2) |
| midi_rx_avail | input | 1 | Receive data available, level (source 3) |
| dma_done | input | 1 | DMA completion event (source 4) |
| tmr_a_ev | input | 1 | Timer A event (source 6) |
| tmr_b_ev | input | 1 | Timer B event (source 7) |
| tmr_c_ev | input | 1 | Timer C event (source 8) |
| midi_tx_empty | input | 1 | Transmit FIFO empty, level (source 9) |
| smp_tick | input | 1 | Per-sample tick (source 10) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| snd_ipl | output | 3 | Sound processor auto-vector level |
| main_irq | output | 1 | Main processor interrupt |
| main_dma_start | output | 1 | One-cycle DMA start pulse |

## Verification
Each source is raised alone while every enable is 0. This shows whether the pending bits are correctly independent of the enables, and whether the source is routed to the right bit. The level sweep programs every code 0 to 7 into the slot of every source in turn, with only that source enabled. This separates mistakes in slot mapping, in bit-slice order and in the handling of code 0. Pairs of sources with different codes, where the higher one is later disabled, distinguish a maximum from a last-wins or OR-based encoder. Clear and pending writes with 0 and with 1 data, applied to one bank, show that the banks are separate and that the level-type bits resist writes.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
  localparam int NSRC   = 11;
  localparam int DW     = 16;
  localparam int AW     = 4;
  localparam int LVW    = 3;
  localparam int NSLOT  = 8;
  localparam int SW_BIT = 5;
  localparam logic [NSRC-1:0] LVL_MASK = NSRC'(11'b010_0000_1000);

  typedef enum logic [AW-1:0] {
    RA_SPEND = 4'd0,
    RA_SEN   = 4'd1,
    RA_SCLR  = 4'd2,
    RA_MPEND = 4'd3,
    RA_MEN   = 4'd4,
    RA_MCLR  = 4'd5,
    RA_LV0   = 4'd6,
    RA_LV1   = 4'd7,
    RA_LV2   = 4'd8
  } reg_sel_e;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import snd_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] lvl_o
);
  logic [NSRC-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = req_i;
    rise_o = req_i & ~prev_q & ~LVL_MASK;
    lvl_o  = req_i & LVL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import snd_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic            we_pend,
  input  logic            we_en,
  input  logic            we_clr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] act_o
);
  logic [NSRC-1:0] pend_q, pend_d, en_q, en_d;
  logic [NSRC-1:0] clr_vec, sw_vec, edge_nxt;

  always_comb begin
    clr_vec  = we_clr ? wdata : '0;
    sw_vec   = '0;
    sw_vec[SW_BIT] = we_pend & wdata[SW_BIT];
    edge_nxt = (pend_q & ~clr_vec) | rise_i | sw_vec;
    pend_d   = (edge_nxt & ~LVL_MASK) | (lvl_i & LVL_MASK);
    en_d     = we_en ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign act_o  = pend_q & en_q;

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i))); // R2
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & LVL_MASK) == $past(lvl_i & LVL_MASK))); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_clr && rise_i == '0) |=> ((pend_q & $past(wdata & ~LVL_MASK)) == '0)); // R4
  AST_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pend && !we_clr && rise_i == '0 && !wdata[SW_BIT])
      |=> ((pend_q & ~LVL_MASK) == $past(pend_q & ~LVL_MASK))); // R5
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
  import snd_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  act_i,
  input  logic [NSLOT-1:0] lv0_i,
  input  logic [NSLOT-1:0] lv1_i,
  input  logic [NSLOT-1:0] lv2_i,
  output logic [LVW-1:0]   ipl_o
);
  logic [LVW-1:0] ipl_q, ipl_d;

  always_comb begin
    ipl_d = '0;
    for (int i = 0; i < NSRC; i++) begin
      int s;
      logic [LVW-1:0] code;
      s    = (i < NSLOT) ? i : NSLOT - 1;
      code = {lv2_i[s], lv1_i[s], lv0_i[s]};
      if (act_i[i] && code > ipl_d) ipl_d = code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ipl_q <= '0;
    else        ipl_q <= ipl_d;
  end

  assign ipl_o = ipl_q;

  AST_IPL_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_q != '0) |-> ($past(act_i) != '0)); // R8
  AST_IPL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act_i) == '0) |-> (ipl_q == '0)); // R8
endmodule

// File: rtl/snd_irq_ctrl.sv
module snd_irq_ctrl
  import snd_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     ext_irq_n,
  input  logic           midi_rx_avail,
  input  logic           dma_done,
  input  logic           tmr_a_ev,
  input  logic           tmr_b_ev,
  input  logic           tmr_c_ev,
  input  logic           midi_tx_empty,
  input  logic           smp_tick,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [LVW-1:0] snd_ipl,
  output logic           main_irq,
  output logic           main_dma_start
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NSRC-1:0] req, rise, lvl;
  always_comb begin
    req        = '0;
    req[2:0]   = ~ext_irq_n;
    req[3]     = midi_rx_avail;
    req[4]     = dma_done;
    req[6]     = tmr_a_ev;
    req[7]     = tmr_b_ev;
    req[8]     = tmr_c_ev;
    req[9]     = midi_tx_empty;
    req[10]    = smp_tick;
  end

  irq_src_cond u_cond (
    .clk(clk), .rst_n(rst_i_n), .req_i(req), .rise_o(rise), .lvl_o(lvl)
  );

  localparam int NBANK = 2;
  logic [NSRC-1:0] pend [NBANK];
  logic [NSRC-1:0] en   [NBANK];
  logic [NSRC-1:0] act  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [AW-1:0] BASE = (b == 0) ? RA_SPEND : RA_MPEND;
    irq_bank u_bank (
      .clk(clk), .rst_n(rst_i_n), .rise_i(rise), .lvl_i(lvl),
      .we_pend(bus_we && bus_addr == BASE),
      .we_en  (bus_we && bus_addr == BASE + AW'(1)),
      .we_clr (bus_we && bus_addr == BASE + AW'(2)),
      .wdata(bus_wdata[NSRC-1:0]),
      .pend_o(pend[b]), .en_o(en[b]), .act_o(act[b])
    );
  end

  logic [NSLOT-1:0] lv_q [LVW];
  logic [NSLOT-1:0] lv_d [LVW];
  always_comb begin
    for (int n = 0; n < LVW; n++) begin
      lv_d[n] = (bus_we && bus_addr == RA_LV0 + AW'(n)) ? bus_wdata[NSLOT-1:0] : lv_q[n];
    end
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int n = 0; n < LVW; n++) lv_q[n] <= '0;
    end else begin
      for (int n = 0; n < LVW; n++) lv_q[n] <= lv_d[n];
    end
  end

  irq_lvl_enc u_enc (
    .clk(clk), .rst_n(rst_i_n), .act_i(act[0]),
    .lv0_i(lv_q[0]), .lv1_i(lv_q[1]), .lv2_i(lv_q[2]), .ipl_o(snd_ipl)
  );

  logic irq_q, irq_d;
  assign main_irq = |act[1];
  assign irq_d    = main_irq;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end
  assign main_dma_start = main_irq & ~irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_SPEND: bus_rdata[NSRC-1:0]  = pend[0];
      RA_SEN:   bus_rdata[NSRC-1:0]  = en[0];
      RA_MPEND: bus_rdata[NSRC-1:0]  = pend[1];
      RA_MEN:   bus_rdata[NSRC-1:0]  = en[1];
      RA_LV0:   bus_rdata[NSLOT-1:0] = lv_q[0];
      RA_LV1:   bus_rdata[NSLOT-1:0] = lv_q[1];
      RA_LV2:   bus_rdata[NSLOT-1:0] = lv_q[2];
      default:  bus_rdata = '0;
    endcase
  end

  AST_MAIN_GATED: assert property (@(posedge clk) disable iff (!rst_i_n)
    main_irq |-> (en[1] != '0)); // R6
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    main_dma_start |=> !main_dma_start); // R9
  AST_TRIG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_i_n)
    main_dma_start |-> (main_irq && !$past(main_irq))); // R9
  AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_rdata[DW-1:NSRC] == '0); // R10
endmodule

// File: tb/tb_snd_irq_ctrl.sv
module tb_snd_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [10:0] src;
  logic bus_we;
  logic [3:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [2:0] snd_ipl;
  logic main_irq, main_dma_start;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  snd_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(~src[2:0]), .midi_rx_avail(src[3]),
    .dma_done(src[4]), .tmr_a_ev(src[6]), .tmr_b_ev(src[7]), .tmr_c_ev(src[8]),
    .midi_tx_empty(src[9]), .smp_tick(src[10]), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snd_ipl(snd_ipl), .main_irq(main_irq), .main_dma_start(main_dma_start)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic bit is_lvl(input int i);
    return (i == 3 || i == 9);
  endfunction

  task automatic raise(input int i);
    if (i == 5) wr(4'd0, 16'h0020);
    else begin
      src[i] = 1'b1; tick();
      if (!is_lvl(i)) src[i] = 1'b0;
    end
    tick();
  endtask

  task automatic clear_all();
    src = '0; tick();
    wr(4'd2, 16'h07FF); wr(4'd5, 16'h07FF);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] r;
    src = '0; bus_we = 0; bus_addr = 0; bus_wdata = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    for (int a = 0; a < 9; a++) begin rd(4'(a), r); chk("R1", r, 16'h0); end
    chk("R1", {13'd0, snd_ipl}, 16'h0);
    chk("R1", {14'd0, main_irq, main_dma_start}, 16'h0);

    // R10 unused bits read zero
    wr(4'd1, 16'hFFFF); rd(4'd1, r); chk("R10", r, 16'h07FF);
    wr(4'd6, 16'hFFFF); rd(4'd6, r); chk("R10", r, 16'h00FF);
    wr(4'd2, 16'hFFFF); rd(4'd2, r); chk("R10", r, 16'h0000);
    wr(4'd1, 16'h0000); wr(4'd6, 16'h0000);

    // R2 / R3 each source alone with all enables 0
    for (int i = 0; i < 11; i++) begin
      clear_all();
      raise(i);
      rd(4'd0, r); chk("R2", r, 16'(1 << i));
      rd(4'd3, r); chk("R2", r, (i == 5) ? 16'h0 : 16'(1 << i));
      chk("R6", {15'd0, main_irq}, 16'h0);
      if (is_lvl(i)) begin
        wr(4'd2, 16'(1 << i)); wr(4'd0, 16'h0000);
        rd(4'd0, r); chk("R3", r, 16'(1 << i));
        src[i] = 1'b0; tick();
        rd(4'd0, r); chk("R3", r, 16'h0);
        rd(4'd3, r); chk("R3", r, 16'h0);
      end
    end

    // R4 clear semantics and bank independence
    clear_all();
    raise(6);
    wr(4'd2, 16'h0000); rd(4'd0, r); chk("R4", r, 16'h0040);
    wr(4'd2, 16'h0040); rd(4'd0, r); chk("R4", r, 16'h0000);
    rd(4'd3, r); chk("R4", r, 16'h0040);
    wr(4'd5, 16'h0040); rd(4'd3, r); chk("R4", r, 16'h0000);

    // R5 software bit only
    clear_all();
    wr(4'd0, 16'h07DF); rd(4'd0, r); chk("R5", r, 16'h0000);
    wr(4'd0, 16'h07FF); rd(4'd0, r); chk("R5", r, 16'h0020);
    rd(4'd3, r); chk("R5", r, 16'h0000);
    wr(4'd3, 16'h0020); rd(4'd3, r); chk("R5", r, 16'h0020);
    wr(4'd0, 16'h0000); rd(4'd0, r); chk("R5", r, 16'h0020);

    // R9 DMA start pulse
    clear_all();
    wr(4'd4, 16'h0040);
    src[6] = 1'b1; tick();
    chk("R9", {14'd0, main_irq, main_dma_start}, 16'h3);
    src[6] = 1'b0; tick();
    chk("R9", {14'd0, main_irq, main_dma_start}, 16'h2);
    tick();
    chk("R9", {14'd0, main_irq, main_dma_start}, 16'h2);
    wr(4'd5, 16'h0040);
    chk("R6", {15'd0, main_irq}, 16'h0);
    wr(4'd4, 16'h0000);

    // R7 / R8 level sweep over every source and code
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < 8; c++) begin
        int s;
        s = (i < 7) ? i : 7;
        clear_all();
        wr(4'd6, 16'((c & 1) << s));
        wr(4'd7, 16'(((c >> 1) & 1) << s));
        wr(4'd8, 16'(((c >> 2) & 1) << s));
        wr(4'd1, 16'(1 << i));
        raise(i);
        chk("R7", {13'd0, snd_ipl}, 16'(c));
      end
    end

    // R8 / R6 maximum of two, then disable the higher one
    clear_all();
    wr(4'd6, 16'h0002); wr(4'd7, 16'h0080); wr(4'd8, 16'h0002);
    wr(4'd1, 16'h0402);
    raise(1); raise(10);
    chk("R8", {13'd0, snd_ipl}, 16'd5);
    wr(4'd1, 16'h0400); tick();
    chk("R6", {13'd0, snd_ipl}, 16'd2);
    wr(4'd1, 16'h0000); tick();
    chk("R8", {13'd0, snd_ipl}, 16'd0);
    wr(4'd1, 16'h0402); wr(4'd6, 16'h0000); wr(4'd7, 16'h0000); wr(4'd8, 16'h0000);
    tick();
    chk("R8", {13'd0, snd_ipl}, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule